// File: doc/BRIEF.md
# Sync Table Lock Arbiter

This block arbitrates between software and hardware over two snapshot tables, one for even and one for odd communication cycles. Hardware copies a table into shared memory during a write window that opens at the end of a cycle of matching parity. Software holds a table steady by locking it. Each table has a single trigger bit that locks the table on one write of 1 and unlocks it on the next. A lock request that arrives while that table's window is open is refused, and it is not remembered. Software must poll the status bit and retry.

The block tracks each table's write window with a per-table counter of `WIN_CLKS` clocks. When a window completes, it marks the table valid. When table generation is disabled, the valid flags lose their meaning, so a counter-update strobe clears both of them. The copying of data into memory is handled elsewhere. This block only produces the window indications that pace that copying.

Top module: `sync_table_lock_arbiter`

## Requirements
- R1: After reset, both lock status bits, both valid flags and both window indications are 0.
- R2: A trigger write (`trig_wr_i`=1) with a table's bit at 1, while that table is unlocked and its window is closed, sets its lock status on the next clock.
- R3: A trigger write of 1 to a table whose window is open leaves its lock status at 0, and the request has no later effect.
- R4: A trigger write of 1 to a locked table clears its lock status on the next clock.
- R5: `cycle_end_i`=1 with `cycle_odd_i`=0 opens the even window, and with `cycle_odd_i`=1 opens the odd window. The window opens on the next clock, provided generation is enabled and the table is unlocked. The window then stays high for exactly `WIN_CLKS` clocks.
- R6: The clock edge that closes a window sets that table's valid flag.
- R7: A table that is locked at the cycle end opens no window and keeps its valid flag. This also applies to a table whose lock is granted in that same cycle.
- R8: With `gen_en_i`=0, a cycle end opens no window.
- R9: `cnt_upd_i`=1 with `gen_en_i`=0 clears both valid flags on the next clock, and this clear wins over a window completing in the same cycle. With `gen_en_i`=1, the strobe has no effect.
- R10: A trigger bit written as 0, or a bit presented without `trig_wr_i`, has no effect. The even bit and the odd bit in one write act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_end_i | input | 1 | One-clock pulse at the end of a communication cycle |
| cycle_odd_i | input | 1 | Parity of the cycle that is ending (1 = odd) |
| gen_en_i | input | 1 | Table generation enable |
| cnt_upd_i | input | 1 | Counter-update strobe |
| trig_wr_i | input | 1 | Host write strobe for the trigger bits |
| trig_even_i | input | 1 | Even table trigger bit |
| trig_odd_i | input | 1 | Odd table trigger bit |
| lock_even_o | output | 1 | Even table lock status |
| lock_odd_o | output | 1 | Odd table lock status |
| valid_even_o | output | 1 | Even table valid flag |
| valid_odd_o | output | 1 | Odd table valid flag |
| win_even_o | output | 1 | Even table write window active |
| win_odd_o | output | 1 | Odd table write window active |

## Verification
The bench targets the following cases:
- **Lock request inside an open window.** A design that queued the request would show the lock rising when the window closes.
- **Lock granted in the same cycle as the cycle end.** A design that checked only the old lock state would open a window over a table that software now holds.
- **Window length, measured clock by clock.** An off-by-one counter would close the window one clock early or one clock late.
- **Clear strobe landing on the clock where a window completes.** A wrong priority would leave a stale valid flag set.
- **Zero writes and one-sided writes to the trigger bits.** A design that coupled the two tables would toggle the wrong lock.

// File: rtl/stla_pkg.sv
package stla_pkg;

  typedef enum logic {
    TBL_EVEN = 1'b0,
    TBL_ODD  = 1'b1
  } tbl_id_e;

  // A cycle end serves the table whose parity equals the ending cycle.
  function automatic logic parity_hit(input tbl_id_e id, input logic cycle_odd);
    return (id == TBL_ODD) == cycle_odd;
  endfunction

  // Next lock state for one toggle request.
  function automatic logic lock_next(input logic lock, input logic busy, input logic req);
    logic nxt;
    nxt = lock;
    if (req) begin
      if (lock)       nxt = 1'b0;
      else if (!busy) nxt = 1'b1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/stla_lock_ctrl.sv
module stla_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  output logic lock_o,
  output logic grant_o
);
  logic lock_q;

  assign grant_o = req_i & ~lock_q & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= stla_pkg::lock_next(lock_q, busy_i, req_i);
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/stla_write_window.sv
module stla_write_window #(
  parameter int WIN_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clr_valid_i,
  output logic win_o,
  output logic valid_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIN_CLKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIN_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             win_q;
  logic             valid_q;

  assign done_o = win_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else if (done_o) begin
      win_q <= 1'b0;
    end else if (win_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      win_q <= 1'b1;
      cnt_q <= LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           valid_q <= 1'b0;
    else if (clr_valid_i) valid_q <= 1'b0;
    else if (done_o)      valid_q <= 1'b1;
  end

  assign win_o   = win_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sync_table_lock_arbiter.sv
module sync_table_lock_arbiter #(
  parameter int WIN_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_end_i,
  input  logic cycle_odd_i,
  input  logic gen_en_i,
  input  logic cnt_upd_i,
  input  logic trig_wr_i,
  input  logic trig_even_i,
  input  logic trig_odd_i,
  output logic lock_even_o,
  output logic lock_odd_o,
  output logic valid_even_o,
  output logic valid_odd_o,
  output logic win_even_o,
  output logic win_odd_o
);
  localparam int NTBL = 2;

  logic [NTBL-1:0] trig_bits;
  logic [NTBL-1:0] req;
  logic [NTBL-1:0] lock;
  logic [NTBL-1:0] grant;
  logic [NTBL-1:0] win;
  logic [NTBL-1:0] valid;
  logic [NTBL-1:0] done;
  logic [NTBL-1:0] wr_start;
  logic            clr_valid;

  assign trig_bits = {trig_odd_i, trig_even_i};
  assign clr_valid = cnt_upd_i & ~gen_en_i;

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    assign req[t] = trig_wr_i & trig_bits[t];

    // A table held, or just granted, at the cycle end is skipped.
    assign wr_start[t] = cycle_end_i & gen_en_i & ~lock[t] & ~grant[t] & ~win[t]
                       & stla_pkg::parity_hit(stla_pkg::tbl_id_e'(t), cycle_odd_i);

    stla_lock_ctrl u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req[t]),
      .busy_i  (win[t]),
      .lock_o  (lock[t]),
      .grant_o (grant[t])
    );

    stla_write_window #(.WIN_CLKS(WIN_CLKS)) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (wr_start[t]),
      .clr_valid_i (clr_valid),
      .win_o       (win[t]),
      .valid_o     (valid[t]),
      .done_o      (done[t])
    );
  end

  assign lock_even_o  = lock[0];
  assign lock_odd_o   = lock[1];
  assign valid_even_o = valid[0];
  assign valid_odd_o  = valid[1];
  assign win_even_o   = win[0];
  assign win_odd_o    = win[1];
endmodule

// File: rtl/stla_checker.sv
module stla_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cycle_end_i,
  input logic       cycle_odd_i,
  input logic       gen_en_i,
  input logic       cnt_upd_i,
  input logic       trig_wr_i,
  input logic       trig_even_i,
  input logic       lock_even_o,
  input logic       valid_even_o,
  input logic       valid_odd_o,
  input logic       win_even_o,
  input logic [1:0] wr_start
);
  a_r2_grant: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_i && trig_even_i && !lock_even_o && !win_even_o |=> lock_even_o);

  a_r3_refuse_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_i && trig_even_i && !lock_even_o && win_even_o |=> !lock_even_o);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_i && trig_even_i && lock_even_o |=> !lock_even_o);

  a_r5_open: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end_i && !cycle_odd_i && gen_en_i && !lock_even_o && !win_even_o
    && !(trig_wr_i && trig_even_i) |=> win_even_o);

  a_r6_valid_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_even_o) |-> $fell(win_even_o));

  a_r7_locked_skip: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end_i && lock_even_o && !win_even_o |=> !win_even_o);

  a_r8_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_i |-> wr_start == 2'b00);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_upd_i && !gen_en_i |=> !valid_even_o && !valid_odd_o);

  a_r5_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_start));
endmodule

bind sync_table_lock_arbiter stla_checker u_stla_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cycle_end_i  (cycle_end_i),
  .cycle_odd_i  (cycle_odd_i),
  .gen_en_i     (gen_en_i),
  .cnt_upd_i    (cnt_upd_i),
  .trig_wr_i    (trig_wr_i),
  .trig_even_i  (trig_even_i),
  .lock_even_o  (lock_even_o),
  .valid_even_o (valid_even_o),
  .valid_odd_o  (valid_odd_o),
  .win_even_o   (win_even_o),
  .wr_start     (wr_start)
);

// File: tb/test_sync_table_lock_arbiter.sv
module test_sync_table_lock_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 0, co = 0, gen = 0, cu = 0, tw = 0, te = 0, to = 0;
  logic le, lo, ve, vo, we, wo;
  int total = 0;
  int bad = 0;
  int cyc_n = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_table_lock_arbiter #(.WIN_CLKS(W)) i_sync_table_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .cycle_end_i(ce), .cycle_odd_i(co),
    .gen_en_i(gen), .cnt_upd_i(cu), .trig_wr_i(tw), .trig_even_i(te),
    .trig_odd_i(to), .lock_even_o(le), .lock_odd_o(lo), .valid_even_o(ve),
    .valid_odd_o(vo), .win_even_o(we), .win_odd_o(wo)
  );

  // {trig_wr, even bit, odd bit, expected even lock, expected odd lock}
  localparam logic [4:0] LOCK_VEC [8] = '{
    5'b110_10, 5'b101_11, 5'b100_11, 5'b011_11,
    5'b111_00, 5'b111_11, 5'b110_01, 5'b101_00
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive inputs for one clock; return after the following edge.
  task automatic step(input logic c_e, c_o, c_u, t_w, t_e, t_o);
    ce = c_e; co = c_o; cu = c_u; tw = t_w; te = t_e; to = t_o;
    @(negedge clk);
    ce = 0; cu = 0; tw = 0; te = 0; to = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 20000) begin
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 lock_even", le, 0); chk("R1 lock_odd", lo, 0);
    chk("R1 valid_even", ve, 0); chk("R1 valid_odd", vo, 0);
    chk("R1 win_even", we, 0); chk("R1 win_odd", wo, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R10 lock toggling table
    foreach (LOCK_VEC[i]) begin
      step(0, 0, 0, LOCK_VEC[i][4], LOCK_VEC[i][3], LOCK_VEC[i][2]);
      chk("R2/R4/R10 even lock", le, LOCK_VEC[i][1]);
      chk("R2/R4/R10 odd lock", lo, LOCK_VEC[i][0]);
    end

    // R5 R6 even window length and completion
    gen = 1;
    step(1, 0, 0, 0, 0, 0);
    chk("R5 even window opens", we, 1);
    chk("R5 odd stays closed", wo, 0);
    // R3 request during window refused
    step(0, 0, 0, 1, 1, 0);
    chk("R3 lock refused", le, 0);
    chk("R5 window held", we, 1);
    for (int k = 0; k < W - 2; k++) begin
      idle();
      chk("R5 window held", we, 1);
      chk("R6 not yet valid", ve, 0);
    end
    idle();
    chk("R5 window closed", we, 0);
    chk("R6 even valid", ve, 1);
    chk("R3 not remembered", le, 0);

    // R5 odd window
    step(1, 1, 0, 0, 0, 0);
    chk("R5 odd window opens", wo, 1);
    chk("R5 even stays closed", we, 0);
    repeat (W) idle();
    chk("R6 odd valid", vo, 1);
    chk("R5 odd closed", wo, 0);

    // R7 locked odd table skipped, valid kept
    step(0, 0, 0, 1, 0, 1);
    chk("R2 odd lock", lo, 1);
    step(1, 1, 0, 0, 0, 0);
    chk("R7 locked skip", wo, 0);
    chk("R7 valid kept", vo, 1);
    step(0, 0, 0, 1, 0, 1);
    chk("R4 odd unlock", lo, 0);

    // R7 grant in same cycle as cycle end
    step(1, 0, 0, 1, 1, 0);
    chk("R7 same-cycle grant", le, 1);
    chk("R7 same-cycle skip", we, 0);
    step(0, 0, 0, 1, 1, 0);
    chk("R4 even unlock", le, 0);

    // R8 generation disabled
    gen = 0;
    step(1, 0, 0, 0, 0, 0);
    chk("R8 no window", we, 0);

    // R9 strobe with generation on: no effect
    gen = 1;
    step(0, 0, 1, 0, 0, 0);
    chk("R9 even valid kept", ve, 1);
    chk("R9 odd valid kept", vo, 1);
    gen = 0;
    step(0, 0, 1, 0, 0, 0);
    chk("R9 even cleared", ve, 0);
    chk("R9 odd cleared", vo, 0);

    // R9 clear beats completion
    gen = 1;
    step(1, 0, 0, 0, 0, 0);
    repeat (W - 1) idle();
    chk("R9 window still open", we, 1);
    gen = 0;
    step(0, 0, 1, 0, 0, 0);
    chk("R9 window closed", we, 0);
    chk("R9 clear wins", ve, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule